// File: doc/BRIEF.md
# Reservation Station Array with Result-Bus Wakeup

This block holds renamed instructions that are waiting for their operands in an out-of-order core. Each slot stores an operation code and two source operands. A source arrives either as a finished value or as the tag of the instruction that will produce it. A slot's index is also its destination tag, which names its result to the rest of the machine. Rename asks for a slot through the allocate port and stalls whenever `alloc_ready` is low. The array picks the lowest-numbered free slot and reports it on `alloc_tag`.

Every waiting source watches a single result bus that carries a tag and a value. When a waiting source sees its producer's tag, it copies the value into the slot. A slot whose two sources are both held raises its bit in `rdy_req`. An outside scheduler answers with a one-hot `grant`. In the same cycle, the granted slot's operands appear on the issue outputs, and the slot is released at that clock edge.

Each slot is a small state machine with three states:
- `SLOT_FREE`: the slot is empty.
- `SLOT_WAIT`: the slot is occupied and at least one source is still missing.
- `SLOT_READY`: the slot is occupied and both sources are held.

Its transitions are:
- *fill-ready*: FREE to READY, when an allocation arrives and both sources are complete.
- *fill-wait*: FREE to WAIT, when an allocation arrives and a source is still missing.
- *wake*: WAIT to READY, when a broadcast completes the last missing source.
- *dispatch*: READY to FREE, when the slot is granted.
- *hold*: every slot keeps its state in all other cases.

Top module: `rs_array`

## Requirements
- R1: After a synchronous reset, every slot is free. `rdy_req` is all zero, `alloc_ready` is 1, `alloc_tag` is 0 and `issue_valid` is 0.
- R2: `alloc_tag` gives the lowest-index free slot, and `alloc_ready` is 1 exactly when at least one slot is free. An allocation attempted while no slot is free changes no slot.
- R3: A slot allocated with both sources already valid raises its `rdy_req` bit in the cycle after the allocate edge.
- R4: A waiting source whose tag equals `bus_tag` while `bus_valid` is 1 stores `bus_data` at that edge. A broadcast of any other tag leaves the source waiting.
- R5: `rdy_req[i]` is 1 only when slot i is occupied and both of its sources are held. Receiving one of two missing sources does not raise it.
- R6: A broadcast whose tag matches a source on the same edge that fills the slot is captured into that slot.
- R7: While `grant` selects a ready slot, `issue_valid` is 1 in the same cycle. In that cycle, `issue_tag`, `issue_op`, `issue_src1` and `issue_src2` show that slot. The slot is free from the next cycle and can be allocated again.
- R8: A grant to a slot that is not ready gives `issue_valid` = 0 and leaves the slot unchanged.
- R9: When `bus_valid` is 0, the bus tag and data have no effect.
- R10: A source that already holds a value keeps it when a later broadcast carries a matching tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Rename requests a slot |
| alloc_op | input | OPC_W | Operation code of the new instruction |
| alloc_src1_ok | input | 1 | Source 1 value is already known |
| alloc_src1_tag | input | TAG_W | Producer tag of source 1 |
| alloc_src1_data | input | DATA_W | Value of source 1 when known |
| alloc_src2_ok | input | 1 | Source 2 value is already known |
| alloc_src2_tag | input | TAG_W | Producer tag of source 2 |
| alloc_src2_data | input | DATA_W | Value of source 2 when known |
| alloc_ready | output | 1 | At least one slot is free |
| alloc_tag | output | TAG_W | Slot (destination tag) that an allocation would fill |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_data | input | DATA_W | Value of the broadcast result |
| grant | input | NUM_ENTRIES | One-hot dispatch grant |
| rdy_req | output | NUM_ENTRIES | Per-slot ready request |
| issue_valid | output | 1 | A ready slot is granted this cycle |
| issue_tag | output | TAG_W | Destination tag of the issued slot |
| issue_op | output | OPC_W | Operation code of the issued slot |
| issue_src1 | output | DATA_W | Source 1 value of the issued slot |
| issue_src2 | output | DATA_W | Source 2 value of the issued slot |

## Verification
The bench builds the array with four slots and 8-bit data. With four slots, the 2-bit tag space is fully covered, so every tag value can be broadcast and every slot can be filled. The fill loop steps through all four combinations of source availability, one per slot, and then tries one more allocation into the full array. A sweep over all four bus tags on the allocate edge separates a forwarded match from a miss. The release order 3, 1, 2, 0 makes the lowest-free pick visible after each grant.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [OPC_W-1:0]  wr_op,
    input  logic              wr_ok1,
    input  logic [TAG_W-1:0]  wr_tag1,
    input  logic [DATA_W-1:0] wr_data1,
    input  logic              wr_ok2,
    input  logic [TAG_W-1:0]  wr_tag2,
    input  logic [DATA_W-1:0] wr_data2,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              grant,
    output logic              busy,
    output logic              ready,
    output logic [OPC_W-1:0]  op,
    output logic [DATA_W-1:0] src1,
    output logic [DATA_W-1:0] src2
);
    slot_state_e       state, state_nx;
    logic              have1, have2, have1_nx, have2_nx;
    logic [TAG_W-1:0]  tag1, tag2, tag1_nx, tag2_nx;
    logic [DATA_W-1:0] val1, val2, val1_nx, val2_nx;
    logic [OPC_W-1:0]  op_q, op_nx;

    // operand capture: fill with same-edge forwarding, or snoop while waiting
    always_comb begin
        have1_nx = have1; have2_nx = have2;
        tag1_nx  = tag1;  tag2_nx  = tag2;
        val1_nx  = val1;  val2_nx  = val2;
        op_nx    = op_q;
        if (state == SLOT_FREE && wr_en) begin
            op_nx   = wr_op;
            tag1_nx = wr_tag1;
            tag2_nx = wr_tag2;
            if (wr_ok1) begin
                have1_nx = 1'b1; val1_nx = wr_data1;
            end else if (bus_valid && bus_tag == wr_tag1) begin
                have1_nx = 1'b1; val1_nx = bus_data;
            end else begin
                have1_nx = 1'b0;
            end
            if (wr_ok2) begin
                have2_nx = 1'b1; val2_nx = wr_data2;
            end else if (bus_valid && bus_tag == wr_tag2) begin
                have2_nx = 1'b1; val2_nx = bus_data;
            end else begin
                have2_nx = 1'b0;
            end
        end else if (state == SLOT_WAIT) begin
            if (!have1 && bus_valid && bus_tag == tag1) begin
                have1_nx = 1'b1; val1_nx = bus_data;
            end
            if (!have2 && bus_valid && bus_tag == tag2) begin
                have2_nx = 1'b1; val2_nx = bus_data;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_FREE:  if (wr_en) state_nx = (have1_nx && have2_nx) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (have1_nx && have2_nx) state_nx = SLOT_READY;
            SLOT_READY: if (grant) state_nx = SLOT_FREE;
            default:    state_nx = SLOT_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= SLOT_FREE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            have1 <= 1'b0;
            have2 <= 1'b0;
        end else begin
            have1 <= have1_nx;
            have2 <= have2_nx;
        end
        tag1 <= tag1_nx;
        tag2 <= tag2_nx;
        val1 <= val1_nx;
        val2 <= val2_nx;
        op_q <= op_nx;
    end

    // outputs
    always_comb begin
        busy  = (state != SLOT_FREE);
        ready = (state == SLOT_READY);
        op    = op_q;
        src1  = val1;
        src2  = val2;
    end
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
    parameter int NUM_ENTRIES = 8,
    localparam int TAG_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] busy,
    output logic                   any_free,
    output logic [TAG_W-1:0]       free_idx
);
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_issue_mux.sv
module rs_issue_mux #(
    parameter int NUM_ENTRIES = 8,
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    localparam int TAG_W = $clog2(NUM_ENTRIES)
) (
    input  logic [NUM_ENTRIES-1:0] pick,
    input  logic [OPC_W-1:0]       op_in   [NUM_ENTRIES],
    input  logic [DATA_W-1:0]      src1_in [NUM_ENTRIES],
    input  logic [DATA_W-1:0]      src2_in [NUM_ENTRIES],
    output logic                   out_valid,
    output logic [TAG_W-1:0]       out_tag,
    output logic [OPC_W-1:0]       out_op,
    output logic [DATA_W-1:0]      out_src1,
    output logic [DATA_W-1:0]      out_src2
);
    always_comb begin
        out_valid = 1'b0;
        out_tag   = '0;
        out_op    = '0;
        out_src1  = '0;
        out_src2  = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (pick[i]) begin
                out_valid = 1'b1;
                out_tag   = TAG_W'(i);
                out_op    = op_in[i];
                out_src1  = src1_in[i];
                out_src2  = src2_in[i];
            end
        end
    end
endmodule

// File: rtl/rs_array.sv
module rs_array #(
    parameter int NUM_ENTRIES = 8,
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    localparam int TAG_W = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_valid,
    input  logic [OPC_W-1:0]       alloc_op,
    input  logic                   alloc_src1_ok,
    input  logic [TAG_W-1:0]       alloc_src1_tag,
    input  logic [DATA_W-1:0]      alloc_src1_data,
    input  logic                   alloc_src2_ok,
    input  logic [TAG_W-1:0]       alloc_src2_tag,
    input  logic [DATA_W-1:0]      alloc_src2_data,
    output logic                   alloc_ready,
    output logic [TAG_W-1:0]       alloc_tag,
    input  logic                   bus_valid,
    input  logic [TAG_W-1:0]       bus_tag,
    input  logic [DATA_W-1:0]      bus_data,
    input  logic [NUM_ENTRIES-1:0] grant,
    output logic [NUM_ENTRIES-1:0] rdy_req,
    output logic                   issue_valid,
    output logic [TAG_W-1:0]       issue_tag,
    output logic [OPC_W-1:0]       issue_op,
    output logic [DATA_W-1:0]      issue_src1,
    output logic [DATA_W-1:0]      issue_src2
);
    logic [NUM_ENTRIES-1:0] slot_busy;
    logic [NUM_ENTRIES-1:0] slot_fill;
    logic [OPC_W-1:0]       slot_op   [NUM_ENTRIES];
    logic [DATA_W-1:0]      slot_src1 [NUM_ENTRIES];
    logic [DATA_W-1:0]      slot_src2 [NUM_ENTRIES];

    rs_free_pick #(.NUM_ENTRIES(NUM_ENTRIES)) u_pick (
        .busy     (slot_busy),
        .any_free (alloc_ready),
        .free_idx (alloc_tag)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        assign slot_fill[g] = alloc_valid && alloc_ready && (alloc_tag == TAG_W'(g));
        rs_slot #(.DATA_W(DATA_W), .OPC_W(OPC_W), .TAG_W(TAG_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (slot_fill[g]),
            .wr_op     (alloc_op),
            .wr_ok1    (alloc_src1_ok),
            .wr_tag1   (alloc_src1_tag),
            .wr_data1  (alloc_src1_data),
            .wr_ok2    (alloc_src2_ok),
            .wr_tag2   (alloc_src2_tag),
            .wr_data2  (alloc_src2_data),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .grant     (grant[g]),
            .busy      (slot_busy[g]),
            .ready     (rdy_req[g]),
            .op        (slot_op[g]),
            .src1      (slot_src1[g]),
            .src2      (slot_src2[g])
        );
    end

    rs_issue_mux #(.NUM_ENTRIES(NUM_ENTRIES), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_mux (
        .pick      (grant & rdy_req),
        .op_in     (slot_op),
        .src1_in   (slot_src1),
        .src2_in   (slot_src2),
        .out_valid (issue_valid),
        .out_tag   (issue_tag),
        .out_op    (issue_op),
        .out_src1  (issue_src1),
        .out_src2  (issue_src2)
    );
endmodule

// File: rtl/rs_array_checker.sv
module rs_array_checker #(
    parameter int NUM_ENTRIES = 8,
    localparam int TAG_W = $clog2(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   alloc_valid,
    input logic                   alloc_ready,
    input logic [TAG_W-1:0]       alloc_tag,
    input logic [NUM_ENTRIES-1:0] grant,
    input logic [NUM_ENTRIES-1:0] rdy_req,
    input logic                   issue_valid,
    input logic [NUM_ENTRIES-1:0] busy_vec
);
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (rdy_req == '0 && alloc_ready));

    a_r2_full_means_busy: assert property (@(posedge clk) disable iff (rst)
        !alloc_ready |-> (&busy_vec));

    a_r2_pick_is_free: assert property (@(posedge clk) disable iff (rst)
        alloc_ready |-> !busy_vec[alloc_tag]);

    a_r5_ready_is_busy: assert property (@(posedge clk) disable iff (rst)
        (rdy_req & ~busy_vec) == '0);

    a_r6_fill_occupies: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_ready) |=> busy_vec[$past(alloc_tag)]);

    a_r7_issue_frees: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && $onehot(grant) && !(alloc_valid && alloc_ready))
        |=> ($countones(busy_vec) + 1 == $past($countones(busy_vec))));

    a_r8_issue_needs_ready: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> ((grant & rdy_req) != '0));
endmodule

bind rs_array rs_array_checker #(.NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_tag   (alloc_tag),
    .grant       (grant),
    .rdy_req     (rdy_req),
    .issue_valid (issue_valid),
    .busy_vec    (slot_busy)
);

// File: tb/test_rs_array.sv
module test_rs_array;
    localparam int NE = 4;
    localparam int DW = 8;
    localparam int OW = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          alloc_valid;
    logic [OW-1:0] alloc_op;
    logic          alloc_src1_ok, alloc_src2_ok;
    logic [TW-1:0] alloc_src1_tag, alloc_src2_tag;
    logic [DW-1:0] alloc_src1_data, alloc_src2_data;
    logic          alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic          bus_valid;
    logic [TW-1:0] bus_tag;
    logic [DW-1:0] bus_data;
    logic [NE-1:0] grant;
    logic [NE-1:0] rdy_req;
    logic          issue_valid;
    logic [TW-1:0] issue_tag;
    logic [OW-1:0] issue_op;
    logic [DW-1:0] issue_src1, issue_src2;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rs_array #(.NUM_ENTRIES(NE), .DATA_W(DW), .OPC_W(OW)) i_rs_array (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_src1_ok(alloc_src1_ok), .alloc_src1_tag(alloc_src1_tag), .alloc_src1_data(alloc_src1_data),
        .alloc_src2_ok(alloc_src2_ok), .alloc_src2_tag(alloc_src2_tag), .alloc_src2_data(alloc_src2_data),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .grant(grant), .rdy_req(rdy_req),
        .issue_valid(issue_valid), .issue_tag(issue_tag), .issue_op(issue_op),
        .issue_src1(issue_src1), .issue_src2(issue_src2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_op = '0;
        alloc_src1_ok = 0; alloc_src1_tag = '0; alloc_src1_data = '0;
        alloc_src2_ok = 0; alloc_src2_tag = '0; alloc_src2_data = '0;
        bus_valid = 0; bus_tag = '0; bus_data = '0;
        grant = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bcast(input logic v, input logic [TW-1:0] t, input logic [DW-1:0] d);
        bus_valid = v; bus_tag = t; bus_data = d;
        tick();
        idle();
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NE-1:0] freed;
        idle();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        #1;
        chk("R1 rdy_req", 32'(rdy_req), 0);
        chk("R1 alloc_ready", 32'(alloc_ready), 1);
        chk("R1 alloc_tag", 32'(alloc_tag), 0);
        chk("R1 issue_valid", 32'(issue_valid), 0);

        // fill: slot p gets source availability pattern p
        for (int p = 0; p < NE; p++) begin
            chk("R2 alloc_tag lowest free", 32'(alloc_tag), 32'(p));
            chk("R2 alloc_ready", 32'(alloc_ready), 1);
            alloc_valid = 1; alloc_op = OW'(p + 3);
            alloc_src1_ok = p[0]; alloc_src1_tag = 2'd1; alloc_src1_data = p[0] ? DW'(8'h10 + p) : 8'hE0;
            alloc_src2_ok = p[1]; alloc_src2_tag = 2'd2; alloc_src2_data = p[1] ? DW'(8'h20 + p) : 8'hE1;
            tick();
            idle();
        end
        chk("R2 full", 32'(alloc_ready), 0);
        chk("R3/R5 only complete slot ready", 32'(rdy_req), 32'b1000);

        // allocate into a full array
        alloc_valid = 1; alloc_op = 4'hF;
        alloc_src1_ok = 1; alloc_src1_data = 8'hEE; alloc_src2_ok = 1; alloc_src2_data = 8'hEE;
        tick();
        idle();
        chk("R2 full alloc ignored rdy", 32'(rdy_req), 32'b1000);
        chk("R2 still full", 32'(alloc_ready), 0);

        bcast(1'b0, 2'd1, 8'h99);
        chk("R9 invalid bus ignored", 32'(rdy_req), 32'b1000);
        bcast(1'b1, 2'd0, 8'h99);
        chk("R4 non-matching tag ignored", 32'(rdy_req), 32'b1000);
        bcast(1'b1, 2'd1, 8'h5A);
        chk("R4/R5 tag1 wakeup", 32'(rdy_req), 32'b1100);

        grant = 4'b0001;
        #1;
        chk("R8 grant to waiting slot", 32'(issue_valid), 0);
        tick();
        idle();
        chk("R8 waiting slot kept", 32'(rdy_req), 32'b1100);
        chk("R8 no slot freed", 32'(alloc_ready), 0);

        bcast(1'b1, 2'd1, 8'h99);
        chk("R10 rebroadcast no wakeup change", 32'(rdy_req), 32'b1100);
        bcast(1'b1, 2'd2, 8'hC3);
        chk("R4 tag2 wakeup", 32'(rdy_req), 32'b1111);

        freed = '0;
        foreach (freed[k]) freed[k] = 1'b0;
        for (int s = 0; s < NE; s++) begin
            int g;
            int low;
            g = (s == 0) ? 3 : (s == 1) ? 1 : (s == 2) ? 2 : 0;
            grant = NE'(1 << g);
            #1;
            chk("R7 issue_valid", 32'(issue_valid), 1);
            chk("R7 issue_tag", 32'(issue_tag), 32'(g));
            chk("R7 issue_op", 32'(issue_op), 32'(g + 3));
            chk("R4/R10 issue_src1", 32'(issue_src1), (g % 2 == 1) ? 32'(8'h10 + g) : 32'h5A);
            chk("R4 issue_src2", 32'(issue_src2), (g >= 2) ? 32'(8'h20 + g) : 32'hC3);
            tick();
            idle();
            freed[g] = 1'b1;
            low = 0;
            for (int k = NE - 1; k >= 0; k--) if (freed[k]) low = k;
            chk("R7 slot released", 32'(rdy_req[g]), 0);
            chk("R7 realloc ready", 32'(alloc_ready), 1);
            chk("R7/R2 lowest freed", 32'(alloc_tag), 32'(low));
        end

        // same-edge forwarding sweep over every bus tag
        for (int t = 0; t < NE; t++) begin
            logic [DW-1:0] exp1;
            alloc_valid = 1; alloc_op = 4'h1;
            alloc_src1_ok = 0; alloc_src1_tag = 2'd2; alloc_src1_data = 8'hE5;
            alloc_src2_ok = 1; alloc_src2_data = DW'(8'h30 + t);
            bus_valid = 1; bus_tag = TW'(t); bus_data = DW'(8'h40 + t);
            tick();
            idle();
            chk("R6 forward on fill", 32'(rdy_req), (t == 2) ? 32'b0001 : 32'b0000);
            exp1 = DW'(8'h42);
            if (t != 2) begin
                bcast(1'b1, 2'd2, DW'(8'h50 + t));
                chk("R4 late wakeup", 32'(rdy_req), 32'b0001);
                exp1 = DW'(8'h50 + t);
            end
            grant = 4'b0001;
            #1;
            chk("R6 issue_src1", 32'(issue_src1), 32'(exp1));
            chk("R3 issue_src2", 32'(issue_src2), 32'(8'h30 + t));
            tick();
            idle();
            chk("R7 freed", 32'(rdy_req), 0);
            chk("R7 slot0 reused", 32'(alloc_tag), 0);
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule